// File: doc/BRIEF.md
# Stream-to-Memory Write Engine

This block drains a flow-controlled word stream coming out of a processing unit into a memory bank. Software programs a base address and a word count through a small register port. Writing the count arms the engine: from then on it accepts one stream word at a time, issues a memory write request carrying the word and its address (base plus the number of words already written), and holds the request until the memory acknowledges it. While a write is in flight, and once the programmed count has been reached, the stream is held off.

There is no separate start command; programming the length is the start. Software tracks progress by reading back the number of words written, and a done output rises when that number matches the programmed length. Done stays up until the next arming, so a later poll still sees a completed transfer.

Top module: `stream_mem_writer`

## Requirements
- R1: After reset the engine is unarmed: s_ready_o, mem_req_o and done_o are low, the count readback is 0, and stream words offered before arming cause no memory request.
- R2: A write to the length register (cfg_sel_i = 2) loads the length, clears the written count to 0 and arms the engine; with a nonzero length s_ready_o is high from the following cycle.
- R3: Each accepted stream word (s_valid_i and s_ready_o high at a clock edge) produces exactly one memory request in the next cycle, with mem_data_o equal to the word and mem_addr_o equal to the start register value at acceptance plus the written count; address and data hold steady while the request waits for acknowledge.
- R4: s_ready_o stays low while a memory request is outstanding.
- R5: The written count increments by one on each acknowledged write and is read at cfg_sel_i = 0; the start address reads back at cfg_sel_i = 1 and the length at cfg_sel_i = 2, zero-extended on cfg_rdata_o.
- R6: When the count equals the length, done_o is high and s_ready_o is low; further stream words are not accepted and the count does not change; done_o stays high until the length register is written again, which clears it (unless the new length is 0).
- R7: Programming a length of 0 raises done_o at once and the stream is never accepted.
- R8: A length write made while a memory request is outstanding is ignored: length, count and armed state are unchanged.
- R9: A start address written during a transfer applies to words accepted afterwards; their address is the new start plus the words already written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 count (read only), 1 start, 2 length |
| cfg_wdata_i | input | CFG_W | Register write data |
| cfg_rdata_o | output | CFG_W | Read-back of the selected register |
| s_valid_i | input | 1 | Stream word valid |
| s_data_i | input | DATA_W | Stream word |
| s_ready_o | output | 1 | Stream accept |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Memory write acknowledge |
| done_o | output | 1 | Programmed length reached |

## Verification
The assertions take for granted that the memory raises mem_ack_i only while mem_req_o is high, for a single cycle per request, and that register writes select only the start or length codes. The bench memory model acknowledges only a pending request, after a programmable delay or never while held, and drops acknowledge in the following cycle; stimulus writes only codes 1 and 2, and the ignored length write of R8 is issued deliberately while the memory model withholds acknowledge.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_START  = 2'd1,
    REG_LENGTH = 2'd2
  } ow_reg_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/ow_cfg_regs.sv
module ow_cfg_regs
  import ow_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CFG_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic [LEN_W-1:0]  cnt_i,
  output logic [CFG_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0] start_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              armed_o,
  output logic              arm_o
);
  logic [ADDR_W-1:0] start_q;
  logic [LEN_W-1:0]  len_q;
  logic              armed_q;
  ow_reg_e           sel;

  assign sel   = ow_reg_e'(sel_i);
  // arming is refused while a write is in flight
  assign arm_o = we_i && (sel == REG_LENGTH) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      len_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (we_i && sel == REG_START) start_q <= wdata_i[ADDR_W-1:0];
      if (arm_o) begin
        len_q   <= wdata_i[LEN_W-1:0];
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      REG_COUNT:  rdata_o = CFG_W'(cnt_i);
      REG_START:  rdata_o = CFG_W'(start_q);
      REG_LENGTH: rdata_o = CFG_W'(len_q);
      default:    rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign len_o   = len_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/ow_write_seq.sv
module ow_write_seq #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              armed_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ack_i,
  output logic [LEN_W-1:0]  cnt_o,
  output logic              done_o,
  output logic              busy_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              full;
  logic              accept;

  assign full      = armed_i && (cnt_q == len_i);
  assign s_ready_o = armed_i && !pend_q && !full && !arm_i;
  assign accept    = s_valid_i && s_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (arm_i) begin
        cnt_q <= '0;
      end else if (pend_q && mem_ack_i) begin
        cnt_q  <= cnt_q + 1'b1;
        pend_q <= 1'b0;
      end
      if (accept) begin
        pend_q <= 1'b1;
        addr_q <= start_i + ADDR_W'(cnt_q);
        data_q <= s_data_i;
      end
    end
  end

  assign mem_req_o  = pend_q;
  assign mem_addr_o = addr_q;
  assign mem_data_o = data_q;
  assign cnt_o      = cnt_q;
  assign done_o     = full;
  assign busy_o     = pend_q;
endmodule

// File: rtl/stream_mem_writer.sv
module stream_mem_writer
  import ow_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CFG_W = (ADDR_W > LEN_W) ? ADDR_W : LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ack_i,
  output logic              done_o
);
  logic [ADDR_W-1:0] start;
  logic [LEN_W-1:0]  len;
  logic [LEN_W-1:0]  cnt;
  logic              armed;
  logic              arm;
  logic              busy;

  ow_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .busy_i  (busy),
    .cnt_i   (cnt),
    .rdata_o (cfg_rdata_o),
    .start_o (start),
    .len_o   (len),
    .armed_o (armed),
    .arm_o   (arm)
  );

  ow_write_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm),
    .armed_i    (armed),
    .start_i    (start),
    .len_i      (len),
    .s_valid_i  (s_valid_i),
    .s_data_i   (s_data_i),
    .s_ready_o  (s_ready_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o),
    .mem_ack_i  (mem_ack_i),
    .cnt_o      (cnt),
    .done_o     (done_o),
    .busy_o     (busy)
  );
endmodule

// File: rtl/ow_checker.sv
module ow_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_valid_i,
  input logic [DATA_W-1:0] s_data_i,
  input logic              s_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic [LEN_W-1:0]  cnt_i,
  input logic              armed_i,
  input logic              arm_i
);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |-> (!s_ready_o && !mem_req_o));

  assert_arm_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (cnt_i == '0));

  assert_accept_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> (mem_req_o && mem_data_o == $past(s_data_i)));

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o)));

  assert_no_ready_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !s_ready_o);

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> (cnt_i == $past(cnt_i) + 1'b1));

  assert_done_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !s_ready_o);

  assert_done_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> done_o);

  assert_pend_no_arm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !arm_i);

  assert_ack_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ack_i |-> mem_req_o);
endmodule

bind stream_mem_writer ow_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_valid_i  (s_valid_i),
  .s_data_i   (s_data_i),
  .s_ready_o  (s_ready_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .mem_ack_i  (mem_ack_i),
  .done_o     (done_o),
  .cnt_i      (cnt),
  .armed_i    (armed),
  .arm_i      (arm)
);

// File: tb/stream_mem_writer_test.sv
`timescale 1ns/1ps
module stream_mem_writer_test;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned LEN_W  = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CFG_W  = 24;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic [1:0]        cfg_sel_i = 2'd0;
  logic [CFG_W-1:0]  cfg_wdata_i = '0;
  logic [CFG_W-1:0]  cfg_rdata_o;
  logic              s_valid_i = 1'b0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic              s_ready_o;
  logic              mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W-1:0] mem_data_o;
  logic              mem_ack_i;
  logic              done_o;

  stream_mem_writer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) uut (.*);

  always #4 clk_i = ~clk_i;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int ack_delay = 0;
  bit ack_hold = 0;
  int wait_cnt = 0;
  logic [ADDR_W-1:0] exp_start = '0;
  int exp_cnt = 0;
  logic [ADDR_W+DATA_W-1:0] sb_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [CFG_W-1:0] val);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = val;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [CFG_W-1:0] val);
    cfg_sel_i = sel;
    #1;
    val = cfg_rdata_o;
  endtask

  // driver: offers one word, records the expected memory write at acceptance
  task automatic push_word(input logic [DATA_W-1:0] d);
    @(negedge clk_i);
    s_valid_i = 1'b1; s_data_i = d;
    while (!s_ready_o) @(negedge clk_i);
    sb_q.push_back({exp_start + ADDR_W'(exp_cnt), d});
    exp_cnt++;
    @(negedge clk_i);
    s_valid_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400 && !done_o; i++) @(negedge clk_i);
  endtask

  // memory model and monitor
  initial begin
    mem_ack_i = 1'b0;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (mem_req_o) begin
        check(!s_ready_o, "R4", "ready during pending write", 64'(s_ready_o), 64'd0);
        if (!ack_hold) begin
          if (wait_cnt >= ack_delay) begin
            if (sb_q.size() == 0)
              check(1'b0, "R3", "unexpected memory write addr", 64'(mem_addr_o), 64'd0);
            else begin
              logic [ADDR_W+DATA_W-1:0] e;
              e = sb_q.pop_front();
              check(mem_addr_o == e[ADDR_W+DATA_W-1:DATA_W], "R3", "write address",
                    64'(mem_addr_o), 64'(e[ADDR_W+DATA_W-1:DATA_W]));
              check(mem_data_o == e[DATA_W-1:0], "R3", "write data",
                    64'(mem_data_o), 64'(e[DATA_W-1:0]));
            end
            mem_ack_i = 1'b1;
            wait_cnt = 0;
          end else wait_cnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    logic [CFG_W-1:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(!s_ready_o, "R1", "ready after reset", 64'(s_ready_o), 64'd0);
    check(!mem_req_o, "R1", "req after reset", 64'(mem_req_o), 64'd0);
    check(!done_o, "R1", "done after reset", 64'(done_o), 64'd0);
    rd(2'd0, v);
    check(v == 0, "R1", "count after reset", 64'(v), 64'd0);
    // R1 words before arming are not taken
    s_valid_i = 1'b1; s_data_i = 32'hDEAD0000;
    repeat (4) @(negedge clk_i);
    check(!mem_req_o, "R1", "req before arming", 64'(mem_req_o), 64'd0);
    s_valid_i = 1'b0;

    // R2/R5 arm with start 0x100, length 8
    cfg_write(2'd1, 24'h000100); exp_start = 24'h000100;
    cfg_write(2'd2, 24'd8); exp_cnt = 0;
    rd(2'd1, v); check(v == 24'h100, "R5", "start readback", 64'(v), 64'h100);
    rd(2'd2, v); check(v == 8, "R5", "length readback", 64'(v), 64'd8);
    rd(2'd0, v); check(v == 0, "R2", "count after arming", 64'(v), 64'd0);
    check(s_ready_o, "R2", "ready after arming", 64'(s_ready_o), 64'd1);
    ack_delay = 0;
    for (int i = 0; i < 8; i++) push_word(32'hA5000000 + 32'(i));
    wait_done();
    rd(2'd0, v); check(v == 8, "R5", "count after 8 writes", 64'(v), 64'd8);
    check(done_o, "R6", "done at length", 64'(done_o), 64'd1);
    check(!s_ready_o, "R6", "ready at length", 64'(s_ready_o), 64'd0);
    check(sb_q.size() == 0, "R3", "outstanding expected writes", 64'(sb_q.size()), 64'd0);

    // R6 words after done are refused
    @(negedge clk_i); s_valid_i = 1'b1; s_data_i = 32'hBAD0BAD0;
    repeat (5) @(negedge clk_i);
    check(!mem_req_o, "R6", "req after done", 64'(mem_req_o), 64'd0);
    s_valid_i = 1'b0;
    rd(2'd0, v); check(v == 8, "R6", "count unchanged after done", 64'(v), 64'd8);
    check(done_o, "R6", "done held", 64'(done_o), 64'd1);

    // R6/R2 rearm with slow memory
    cfg_write(2'd1, 24'h002000); exp_start = 24'h002000;
    cfg_write(2'd2, 24'd5); exp_cnt = 0;
    check(!done_o, "R6", "done cleared by rearm", 64'(done_o), 64'd0);
    rd(2'd0, v); check(v == 0, "R2", "count cleared by rearm", 64'(v), 64'd0);
    ack_delay = 3;
    for (int i = 0; i < 5; i++) push_word(32'h5A5A0000 ^ 32'(i * 37));
    wait_done();
    check(done_o, "R6", "done after 5 slow writes", 64'(done_o), 64'd1);
    rd(2'd0, v); check(v == 5, "R5", "count after slow writes", 64'(v), 64'd5);

    // R9 start moved mid-transfer
    ack_delay = 1;
    cfg_write(2'd1, 24'h003000); exp_start = 24'h003000;
    cfg_write(2'd2, 24'd4); exp_cnt = 0;
    push_word(32'h11111111);
    push_word(32'h22222222);
    cfg_write(2'd1, 24'h003800); exp_start = 24'h003800;
    push_word(32'h33333333);
    push_word(32'h44444444);
    wait_done();
    check(sb_q.size() == 0, "R9", "writes after start change", 64'(sb_q.size()), 64'd0);

    // R7 zero length
    cfg_write(2'd2, 24'd0); exp_cnt = 0;
    check(done_o, "R7", "done at zero length", 64'(done_o), 64'd1);
    @(negedge clk_i); s_valid_i = 1'b1; s_data_i = 32'h0;
    repeat (4) @(negedge clk_i);
    check(!mem_req_o, "R7", "req at zero length", 64'(mem_req_o), 64'd0);
    check(!s_ready_o, "R7", "ready at zero length", 64'(s_ready_o), 64'd0);
    s_valid_i = 1'b0;

    // R8 length write while pending is ignored
    ack_delay = 0;
    cfg_write(2'd1, 24'h000040); exp_start = 24'h000040;
    cfg_write(2'd2, 24'd3); exp_cnt = 0;
    ack_hold = 1;
    push_word(32'hCAFE0001);
    repeat (2) @(negedge clk_i);
    cfg_write(2'd2, 24'd9);
    rd(2'd2, v); check(v == 3, "R8", "length after ignored write", 64'(v), 64'd3);
    ack_hold = 0;
    repeat (4) @(negedge clk_i);
    rd(2'd0, v); check(v == 1, "R8", "count not cleared by ignored write", 64'(v), 64'd1);
    push_word(32'hCAFE0002);
    push_word(32'hCAFE0003);
    wait_done();
    check(done_o, "R8", "done at original length", 64'(done_o), 64'd1);
    rd(2'd0, v); check(v == 3, "R8", "final count", 64'(v), 64'd3);
    check(sb_q.size() == 0, "R3", "all writes seen", 64'(sb_q.size()), 64'd0);

    repeat (3) @(negedge clk_i);
    summary();
  end
endmodule